// File: doc/BRIEF.md
# Descriptor-Chained Frame DMA Channel

This block is a single display DMA channel that follows a linked list of frame descriptors held in memory. A one-cycle frame-start pulse tells it to fetch the next descriptor. Each descriptor is four 32-bit words. The channel takes them as the link to the following descriptor, the frame source address, a frame identifier and a command word, and keeps all four in registers. Software can also place a branch request in a branch register. The next frame start then fetches from the branch address rather than from the stored link, which lets software redirect the chain at a frame boundary.

After the fetch, the channel sorts the frame into one of three outcomes: a palette load, a pixel frame, or a bus error if the source address is zero or lies outside the permitted memory windows. It signals the outcome with one-cycle event pulses. For a pixel frame, the command word decides whether start-of-frame and end-of-frame events are raised. A small register port gives software access to the descriptor registers and the branch register. The descriptor-address register is the only one of the fetched words that software can write.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset, every register reads zero, `busy` is low and no memory request is made.
- R2: The four fetched words read back at register offsets 0x200+16*CH_ID plus 0x0 (link), 0x4 (source), 0x8 (frame ID) and 0xC (command). A write to the link register clears its low 4 bits. Writes to the source, frame ID and command registers are ignored.
- R3: The branch register sits at offset BRANCH_OFF (default 0x020). Bit 0 is the branch request, bit 1 enables the branch event, and bits 31:4 hold the branch address. A write stores the value ANDed with 0xFFFFFFF3.
- R4: A frame start with no branch request fetches four words starting at the link register address and latches them in order as link, source, frame ID and command.
- R5: A frame start with a branch request set fetches from the branch address (bits 3:0 zero) and clears bit 0 of the branch register. `evt_branch` pulses once, one cycle after the start, only when bit 1 is set.
- R6: For a pixel frame, `evt_sof` pulses when command bit 22 is set, and `evt_eof` pulses exactly one cycle after the start-of-frame slot when command bit 21 is set. Each is independent of the other.
- R7: A frame whose command bit 26 is set pulses `evt_palette` and raises neither start-of-frame nor end-of-frame, whatever bits 21 and 22 hold.
- R8: A fetched source address of zero, or one outside both windows (inclusive of the window end), pulses `evt_bus_err`. The frame then raises no palette, start-of-frame or end-of-frame event.
- R9: The source register is cleared at each frame start. If the 16-byte descriptor does not lie wholly inside a window, no memory request is made, the source reads zero and a bus error is raised.
- R10: A frame-start pulse that arrives while `busy` is high is ignored and causes no second fetch.
- R11: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R12: If software writes the branch register in the same cycle a frame start is accepted, the fetch uses the previous branch contents and the register keeps the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a descriptor fetch |
| reg_addr | input | RA_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 32 | Response beat data, four beats in order |
| busy | output | 1 | Channel is fetching or reporting a frame |
| evt_branch | output | 1 | Branch taken with event enabled |
| evt_sof | output | 1 | Start of pixel frame |
| evt_eof | output | 1 | End of pixel frame |
| evt_palette | output | 1 | Palette-load frame |
| evt_bus_err | output | 1 | Bus error for this frame |

## Verification
Two actions can land in the same cycle. One is a software write to the branch register. The other is the channel accepting a frame start, which consumes the branch request and clears its bit. The bench drives both on the same clock edge and then judges two things: the fetched frame ID must show that the old branch address was used, and a read of the branch register must return the newly written value with its request bit still set. The next frame start must then fetch from the new address. A second overlap is a frame-start pulse that arrives while the memory port is stalled. The bench judges it by counting accepted requests and by checking that the request address stays stable.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_DATA,
      ST_CLASS,
      ST_EOF
   } fdd_state_e;

   localparam int          WORD_W      = 32;
   localparam int          DESC_WORDS  = 4;
   localparam int          DESC_BYTES  = DESC_WORDS * 4;
   localparam int          BEAT_W      = $clog2(DESC_WORDS);
   localparam int          CMD_EOF_BIT = 21;
   localparam int          CMD_SOF_BIT = 22;
   localparam int          CMD_PAL_BIT = 26;
   localparam int          BR_REQ_BIT  = 0;
   localparam int          BR_INT_BIT  = 1;
   localparam logic [31:0] BR_WMASK    = 32'hFFFF_FFF3;
   localparam logic [31:0] LINK_WMASK  = 32'hFFFF_FFF0;
endpackage

// File: rtl/fdd_win_check.sv
module fdd_win_check #(
   parameter logic [31:0] WIN0_BASE = 32'h0000_1000,
   parameter logic [31:0] WIN0_SIZE = 32'h0000_1000,
   parameter logic [31:0] WIN1_BASE = 32'h8000_0000,
   parameter logic [31:0] WIN1_SIZE = 32'h0000_0100,
   parameter int          SPAN      = 0
) (
   input  logic [31:0] addr,
   output logic        ok
);
   localparam int NWIN = 2;
   localparam logic [NWIN*32-1:0] BASES = {WIN1_BASE, WIN0_BASE};
   localparam logic [NWIN*32-1:0] SIZES = {WIN1_SIZE, WIN0_SIZE};

   logic [NWIN-1:0] hit;

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      logic [32:0] lo, hi, a_lo, a_hi;
      assign lo   = {1'b0, BASES[g*32 +: 32]};
      assign hi   = lo + {1'b0, SIZES[g*32 +: 32]};
      assign a_lo = {1'b0, addr};
      assign a_hi = a_lo + 33'(SPAN);
      assign hit[g] = (a_lo >= lo) && (a_hi <= hi);
   end

   assign ok = |hit;
endmodule

// File: rtl/fdd_regs.sv
module fdd_regs
   import fdd_pkg::*;
#(
   parameter int          RA_W       = 12,
   parameter logic [11:0] LINK_OFF   = 12'h200,
   parameter logic [11:0] BRANCH_OFF = 12'h020
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] reg_addr,
   input  logic            reg_wr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            clr_src,
   input  logic            clr_breq,
   input  logic            ld_en,
   input  logic [BEAT_W-1:0] ld_idx,
   input  logic [31:0]     ld_data,
   output logic [31:0]     link_q,
   output logic [31:0]     br_q,
   output logic [31:0]     src_q,
   output logic [31:0]     cmd_q
);
   logic [31:0] fid_q;
   logic        wr_link, wr_br;

   assign wr_link = reg_wr && (reg_addr == RA_W'(LINK_OFF));
   assign wr_br   = reg_wr && (reg_addr == RA_W'(BRANCH_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= '0;
         br_q   <= '0;
         src_q  <= '0;
         fid_q  <= '0;
         cmd_q  <= '0;
      end else begin
         if (ld_en && ld_idx == 2'd0) link_q <= ld_data;
         else if (wr_link)            link_q <= reg_wdata & LINK_WMASK;

         if (wr_br)         br_q <= reg_wdata & BR_WMASK;
         else if (clr_breq) br_q[BR_REQ_BIT] <= 1'b0;

         if (clr_src)                      src_q <= '0;
         else if (ld_en && ld_idx == 2'd1) src_q <= ld_data;

         if (ld_en && ld_idx == 2'd2) fid_q <= ld_data;
         if (ld_en && ld_idx == 2'd3) cmd_q <= ld_data;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == RA_W'(LINK_OFF))       reg_rdata = link_q;
      else if (reg_addr == RA_W'(LINK_OFF + 4))   reg_rdata = src_q;
      else if (reg_addr == RA_W'(LINK_OFF + 8))   reg_rdata = fid_q;
      else if (reg_addr == RA_W'(LINK_OFF + 12))  reg_rdata = cmd_q;
      else if (reg_addr == RA_W'(BRANCH_OFF))     reg_rdata = br_q;
   end
endmodule

// File: rtl/fdd_fetch.sv
module fdd_fetch
   import fdd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [31:0]       fetch_addr,
   input  logic              fetch_ok,
   input  logic              src_ok,
   input  logic              br_req,
   input  logic              br_int,
   input  logic [31:0]       cmd_q,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [31:0]       mem_req_addr,
   input  logic              mem_rsp_valid,
   output logic              clr_src,
   output logic              clr_breq,
   output logic              ld_en,
   output logic [BEAT_W-1:0] ld_idx,
   output logic              busy,
   output logic              evt_branch,
   output logic              evt_sof,
   output logic              evt_eof,
   output logic              evt_palette,
   output logic              evt_bus_err
);
   fdd_state_e        st_q;
   logic [31:0]       addr_q;
   logic [BEAT_W-1:0] beat_q;
   logic              br_evt_q;
   logic              accept;

   assign accept   = (st_q == ST_IDLE) && frame_start;
   assign clr_src  = accept;
   assign clr_breq = accept && br_req;
   assign ld_en    = (st_q == ST_DATA) && mem_rsp_valid;
   assign ld_idx   = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         beat_q   <= '0;
         br_evt_q <= 1'b0;
      end else begin
         br_evt_q <= accept && br_req && br_int;
         case (st_q)
            ST_IDLE: if (frame_start) begin
               addr_q <= fetch_addr;
               beat_q <= '0;
               st_q   <= fetch_ok ? ST_REQ : ST_CLASS;
            end
            ST_REQ:  if (mem_req_ready) st_q <= ST_DATA;
            ST_DATA: if (mem_rsp_valid) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == BEAT_W'(DESC_WORDS - 1)) st_q <= ST_CLASS;
            end
            ST_CLASS: st_q <= (src_ok && !cmd_q[CMD_PAL_BIT]) ? ST_EOF : ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (st_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign busy          = (st_q != ST_IDLE);
   assign evt_branch    = br_evt_q;
   assign evt_bus_err   = (st_q == ST_CLASS) && !src_ok;
   assign evt_palette   = (st_q == ST_CLASS) && src_ok && cmd_q[CMD_PAL_BIT];
   assign evt_sof       = (st_q == ST_CLASS) && src_ok && !cmd_q[CMD_PAL_BIT]
                          && cmd_q[CMD_SOF_BIT];
   assign evt_eof       = (st_q == ST_EOF) && cmd_q[CMD_EOF_BIT];
endmodule

// File: rtl/frame_desc_dma.sv
module frame_desc_dma
   import fdd_pkg::*;
#(
   parameter int          RA_W       = 12,
   parameter int          CH_ID      = 0,
   parameter logic [11:0] BRANCH_OFF = 12'h020,
   parameter logic [31:0] WIN0_BASE  = 32'h0000_1000,
   parameter logic [31:0] WIN0_SIZE  = 32'h0000_1000,
   parameter logic [31:0] WIN1_BASE  = 32'h8000_0000,
   parameter logic [31:0] WIN1_SIZE  = 32'h0000_0100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start,
   input  logic [RA_W-1:0] reg_addr,
   input  logic            reg_wr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [31:0]     mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [31:0]     mem_rsp_data,
   output logic            busy,
   output logic            evt_branch,
   output logic            evt_sof,
   output logic            evt_eof,
   output logic            evt_palette,
   output logic            evt_bus_err
);
   localparam logic [11:0] LINK_OFF = 12'(12'h200 + CH_ID * 16);

   if (int'(LINK_OFF) + 12 >= (1 << RA_W)) begin : g_bad_ra
      $error("frame_desc_dma: channel registers exceed RA_W");
   end
   if (BRANCH_OFF >= LINK_OFF && BRANCH_OFF < LINK_OFF + 16) begin : g_bad_br
      $error("frame_desc_dma: branch register overlaps descriptor registers");
   end
   if (WIN0_SIZE == 0 || WIN1_SIZE == 0) begin : g_bad_win
      $error("frame_desc_dma: memory windows must be non-empty");
   end

   logic              clr_src, clr_breq, ld_en;
   logic [BEAT_W-1:0] ld_idx;
   logic [31:0]       link_q, br_q, src_q, cmd_q, fetch_addr;
   logic              fetch_ok, src_win_ok, src_ok;

   assign fetch_addr = br_q[BR_REQ_BIT] ? {br_q[31:4], 4'b0000} : link_q;
   assign src_ok     = src_win_ok && (src_q != '0);

   fdd_regs #(.RA_W(RA_W), .LINK_OFF(LINK_OFF), .BRANCH_OFF(BRANCH_OFF)) u_regs (
      .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
      .clr_src, .clr_breq, .ld_en, .ld_idx, .ld_data(mem_rsp_data),
      .link_q, .br_q, .src_q, .cmd_q
   );

   fdd_win_check #(.WIN0_BASE(WIN0_BASE), .WIN0_SIZE(WIN0_SIZE),
                   .WIN1_BASE(WIN1_BASE), .WIN1_SIZE(WIN1_SIZE),
                   .SPAN(DESC_BYTES)) u_desc_win (
      .addr(fetch_addr), .ok(fetch_ok)
   );

   fdd_win_check #(.WIN0_BASE(WIN0_BASE), .WIN0_SIZE(WIN0_SIZE),
                   .WIN1_BASE(WIN1_BASE), .WIN1_SIZE(WIN1_SIZE),
                   .SPAN(0)) u_src_win (
      .addr(src_q), .ok(src_win_ok)
   );

   fdd_fetch u_fetch (
      .clk, .rst_n, .frame_start, .fetch_addr, .fetch_ok, .src_ok,
      .br_req(br_q[BR_REQ_BIT]), .br_int(br_q[BR_INT_BIT]), .cmd_q,
      .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid,
      .clr_src, .clr_breq, .ld_en, .ld_idx, .busy,
      .evt_branch, .evt_sof, .evt_eof, .evt_palette, .evt_bus_err
   );
endmodule

// File: rtl/fdd_checker.sv
module fdd_checker #(
   parameter int          RA_W       = 12,
   parameter logic [11:0] BRANCH_OFF = 12'h020
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_start,
   input logic [RA_W-1:0] reg_addr,
   input logic [31:0]     reg_rdata,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [31:0]     mem_req_addr,
   input logic            busy,
   input logic            evt_branch,
   input logic            evt_sof,
   input logic            evt_eof,
   input logic            evt_palette,
   input logic            evt_bus_err
);
   // R11: request held with a stable address until accepted
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R6 R7 R8: at most one frame outcome event per cycle
   a_r8_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_sof, evt_eof, evt_palette, evt_bus_err}));

   // R5: branch event only right after a frame start
   a_r5_branch_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      evt_branch |-> $past(frame_start));

   // R10: a fetch begins only on the cycle after an accepted start
   a_r10_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(frame_start) && $past(!busy));

   // R10: requests only while busy
   a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);

   // R3: branch register never reads back bits 3:2
   a_r3_branch_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_W'(BRANCH_OFF)) |-> (reg_rdata[3:2] == 2'b00));
endmodule

bind frame_desc_dma fdd_checker #(.RA_W(RA_W), .BRANCH_OFF(BRANCH_OFF)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .busy(busy),
   .evt_branch(evt_branch), .evt_sof(evt_sof), .evt_eof(evt_eof),
   .evt_palette(evt_palette), .evt_bus_err(evt_bus_err)
);

// File: tb/tb_frame_desc_dma.sv
`timescale 1ns/1ps
module tb_frame_desc_dma;
   localparam int CLK_PERIOD = 10;
   localparam int RA_W = 12;
   localparam logic [11:0] A_LINK = 12'h200, A_SRC = 12'h204, A_FID = 12'h208,
                           A_CMD = 12'h20C, A_BR = 12'h020;

   logic clk = 0, rst_n = 0, frame_start = 0;
   logic [RA_W-1:0] reg_addr = '0;
   logic reg_wr = 0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req_valid, mem_req_ready = 1, mem_rsp_valid;
   logic [31:0] mem_req_addr, mem_rsp_data;
   logic busy, evt_branch, evt_sof, evt_eof, evt_palette, evt_bus_err;

   int checks = 0, errors = 0;
   int n_req = 0, n_sof = 0, n_eof = 0, n_pal = 0, n_ber = 0, n_br = 0;
   int cyc = 0, sof_cyc = 0, eof_cyc = 0;

   logic [31:0] mem [256];
   logic [31:0] cap_addr = '0;
   int          beats_left = 0;
   logic [7:0]  rd_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_desc_dma dut (
      .clk, .rst_n, .frame_start, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
      .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
      .busy, .evt_branch, .evt_sof, .evt_eof, .evt_palette, .evt_bus_err
   );

   // memory responder: four beats after each accepted request
   assign rd_idx        = 8'(cap_addr[9:2] + 8'(4 - beats_left));
   assign mem_rsp_valid = (beats_left != 0);
   assign mem_rsp_data  = mem[rd_idx];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) beats_left <= 0;
      else if (beats_left != 0) beats_left <= beats_left - 1;
      else if (mem_req_valid && mem_req_ready) begin
         cap_addr   <= mem_req_addr;
         beats_left <= 4;
         n_req      <= n_req + 1;
      end
      if (rst_n) begin
         if (evt_sof)     begin n_sof <= n_sof + 1; sof_cyc <= cyc; end
         if (evt_eof)     begin n_eof <= n_eof + 1; eof_cyc <= cyc; end
         if (evt_palette) n_pal <= n_pal + 1;
         if (evt_bus_err) n_ber <= n_ber + 1;
         if (evt_branch)  n_br  <= n_br + 1;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic put_desc(int base, logic [31:0] nxt, src, fid, cmd);
      mem[base] = nxt; mem[base+1] = src; mem[base+2] = fid; mem[base+3] = cmd;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 60 && busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic frame();
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
      wait_idle();
   endtask

   int s_sof, s_eof, s_pal, s_ber, s_br, s_req;
   task automatic snap();
      s_sof = n_sof; s_eof = n_eof; s_pal = n_pal; s_ber = n_ber; s_br = n_br; s_req = n_req;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 busy", 32'(busy), 0);
      chk("R1 req", 32'(mem_req_valid), 0);
      rd(A_LINK, d); chk("R1 link", d, 0);
      rd(A_SRC, d);  chk("R1 src", d, 0);
      rd(A_FID, d);  chk("R1 fid", d, 0);
      rd(A_CMD, d);  chk("R1 cmd", d, 0);
      rd(A_BR, d);   chk("R1 branch", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(A_LINK, 32'h0000_1237); rd(A_LINK, d); chk("R2 link mask", d, 32'h0000_1230);
      wr(A_SRC, 32'hFFFF_FFFF); rd(A_SRC, d); chk("R2 src read-only", d, 0);
      wr(A_FID, 32'hFFFF_FFFF); rd(A_FID, d); chk("R2 fid read-only", d, 0);
      wr(A_CMD, 32'hFFFF_FFFF); rd(A_CMD, d); chk("R2 cmd read-only", d, 0);
      wr(A_BR, 32'hFFFF_FFFC); rd(A_BR, d); chk("R3 branch mask", d, 32'hFFFF_FFF0);
      wr(A_BR, 32'h0);
   endtask

   task automatic t_pixel();
      logic [31:0] d;
      wr(A_LINK, 32'h1000); snap(); frame();
      rd(A_LINK, d); chk("R4 link", d, 32'h1040);
      rd(A_SRC, d);  chk("R4 src", d, 32'h1800);
      rd(A_FID, d);  chk("R4 fid", d, 32'hA5);
      rd(A_CMD, d);  chk("R4 cmd", d, 32'h0060_0100);
      chk("R4 one request", 32'(n_req - s_req), 1);
      chk("R6 sof", 32'(n_sof - s_sof), 1);
      chk("R6 eof", 32'(n_eof - s_eof), 1);
      chk("R6 eof one cycle after sof", 32'(eof_cyc - sof_cyc), 1);
      // chained to B: sof only
      snap(); frame();
      rd(A_FID, d); chk("R4 chain fid", d, 32'hB6);
      chk("R6 sof only", 32'(n_sof - s_sof), 1);
      chk("R6 no eof", 32'(n_eof - s_eof), 0);
      wr(A_LINK, 32'h1140); snap(); frame();
      chk("R6 no bits no sof", 32'(n_sof - s_sof), 0);
      chk("R6 no bits no eof", 32'(n_eof - s_eof), 0);
   endtask

   task automatic t_palette();
      wr(A_LINK, 32'h1080); snap(); frame();
      chk("R7 palette", 32'(n_pal - s_pal), 1);
      chk("R7 no sof", 32'(n_sof - s_sof), 0);
      chk("R7 no eof", 32'(n_eof - s_eof), 0);
   endtask

   task automatic t_bad_src();
      wr(A_LINK, 32'h10C0); snap(); frame();
      chk("R8 zero src error", 32'(n_ber - s_ber), 1);
      chk("R8 zero src no sof", 32'(n_sof - s_sof), 0);
      wr(A_LINK, 32'h1100); snap(); frame();
      chk("R8 window src error", 32'(n_ber - s_ber), 1);
      chk("R8 no palette/eof", 32'(n_pal - s_pal + n_eof - s_eof), 0);
   endtask

   task automatic t_bad_desc();
      logic [31:0] d;
      wr(A_LINK, 32'h1000); frame();
      wr(A_LINK, 32'h5000); snap(); frame();
      chk("R9 no request", 32'(n_req - s_req), 0);
      rd(A_SRC, d); chk("R9 src cleared", d, 0);
      chk("R9 bus error", 32'(n_ber - s_ber), 1);
   endtask

   task automatic t_branch();
      logic [31:0] d;
      wr(A_LINK, 32'h1000); wr(A_BR, 32'h0000_1083); snap(); frame();
      rd(A_FID, d); chk("R5 branch target", d, 32'hC7);
      rd(A_BR, d);  chk("R5 request cleared", d, 32'h0000_1082);
      chk("R5 branch event", 32'(n_br - s_br), 1);
      wr(A_BR, 32'h0000_1041); snap(); frame();
      rd(A_FID, d); chk("R5 branch target 2", d, 32'hB6);
      chk("R5 no event when disabled", 32'(n_br - s_br), 0);
   endtask

   task automatic t_busy_ignore();
      wr(A_LINK, 32'h1000); snap();
      @(negedge clk); mem_req_ready = 0; frame_start = 1;
      @(negedge clk); frame_start = 0;
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
      chk("R11 valid held", 32'(mem_req_valid), 1);
      chk("R11 address held", mem_req_addr, 32'h1000);
      mem_req_ready = 1;
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R10 single fetch", 32'(n_req - s_req), 1);
      chk("R10 idle after", 32'(busy), 0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      wr(A_LINK, 32'h1000); wr(A_BR, 32'h0000_1041);
      @(negedge clk); frame_start = 1; reg_addr = A_BR; reg_wdata = 32'h0000_1141; reg_wr = 1;
      @(negedge clk); frame_start = 0; reg_wr = 0;
      wait_idle();
      rd(A_FID, d); chk("R12 old branch used", d, 32'hB6);
      rd(A_BR, d);  chk("R12 write kept", d, 32'h0000_1141);
      frame();
      rd(A_FID, d); chk("R12 new branch next", d, 32'hF0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      put_desc(0,  32'h1040, 32'h1800,      32'hA5, 32'h0060_0100);
      put_desc(16, 32'h1000, 32'h8000_0010, 32'hB6, 32'h0040_0040);
      put_desc(32, 32'h1000, 32'h1400,      32'hC7, 32'h0460_0400);
      put_desc(48, 32'h1000, 32'h0,         32'hD8, 32'h0060_0000);
      put_desc(64, 32'h1000, 32'h3000,      32'hE9, 32'h0060_0000);
      put_desc(80, 32'h1000, 32'h1900,      32'hF0, 32'h0000_0080);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pixel();
      t_palette();
      t_bad_src();
      t_bad_desc();
      t_branch();
      t_busy_ignore();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule